// File: doc/BRIEF.md
# Hall Commutation Decoder

This block turns the three digital Hall sensor levels of a three-phase brushless motor, together with a direction select, into six gate enables: one upper and one lower switch enable for each phase. Each phase is driven in one of three states. HIGH means the upper switch is on and the lower switch is off. LOW means the upper switch is off and the lower switch is on. OFF means both switches are off.

The phase that is HIGH is chopped by a PWM on/off input. During the PWM off time, synchronous rectification turns on that phase's lower switch instead. Several inputs force safe patterns: stop, initial reset, a supply monitor with hysteresis, overtemperature and a current limit. A current-limit event blanks the upper switches until the next PWM period starts.

Every switch change passes through a per-phase dead-time stage, so the two switches of a phase are never on together.

Top module: `hall_commutator`

## Requirements
- R1: With `rev_i`=0, the Hall key (sensor1,sensor2,sensor3) = (`hall_i[0]`,`hall_i[1]`,`hall_i[2]`) selects the phases (1,2,3) as follows: 010→HIGH,LOW,OFF; 011→HIGH,OFF,LOW; 001→OFF,HIGH,LOW; 101→LOW,HIGH,OFF; 100→LOW,OFF,HIGH; 110→OFF,LOW,HIGH. Phase n uses `up_en_o[n-1]`/`lo_en_o[n-1]`. HIGH is up=1,lo=0; LOW is up=0,lo=1; OFF is both 0.
- R2: With `rev_i`=1, the bitwise complement of each key in R1 produces the same phase pattern.
- R3: The upper enable of the HIGH phase follows `pwm_on_i`. While `pwm_on_i`=0, the lower enable of that phase is on instead (synchronous rectification, `SYNC_RECT`=1).
- R4: Keys 000 and 111 turn all six enables off.
- R5: `stop_i` or `init_rst_i` high turns all six enables off.
- R6: The supply monitor locks all six enables off when `vsup_i` < `UV_FALL`. Once locked, it stays locked until `vsup_i` >= `UV_RISE` (`UV_RISE` > `UV_FALL`). It comes out of reset locked.
- R7: `ovt_i` high turns all upper enables off. The lower enables keep following R1 to R3.
- R8: `ilim_i` high turns all upper enables off in the following cycle. They stay off until a PWM period start, which is a cycle in which `pwm_on_i` is 1 after having been 0.
- R9: `up_en_o[n]` and `lo_en_o[n]` are never 1 together.
- R10: A switch enable rises only after its phase has had both enables at 0 for at least `DEAD_CYC`+1 consecutive cycles. This holds for every change, including a reversal of direction.
- R11: All enables are 0 during reset. Enables are registered, so a requested turn-off shows on the outputs one clock after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_i | input | 3 | Hall sensor levels, bit0 = sensor 1 |
| rev_i | input | 1 | Direction select, 1 = reverse |
| pwm_on_i | input | 1 | PWM on-time indicator |
| stop_i | input | 1 | Stop request |
| init_rst_i | input | 1 | Initial-reset hold |
| vsup_i | input | VW | Digitised supply level |
| ovt_i | input | 1 | Overtemperature flag |
| ilim_i | input | 1 | Current-limit trip |
| up_en_o | output | 3 | Upper switch enables, bit n = phase n+1 |
| lo_en_o | output | 3 | Lower switch enables, bit n = phase n+1 |

## Verification
The bench builds the block with `DEAD_CYC`=2, an 8-bit supply code, `UV_FALL`=100 and `UV_RISE`=112. The short dead time lets every commutation step, PWM edge and direction reversal complete within a few cycles, so the bench can walk all twelve keys and chop the PWM repeatedly in a short run. The close thresholds let a supply code of 105 probe the hysteresis band from both sides.

// File: rtl/hcd_pkg.sv
package hcd_pkg;
   localparam int NPH = 3;

   typedef enum logic [1:0] {
      PH_OFF  = 2'b00,
      PH_HIGH = 2'b01,
      PH_LOW  = 2'b10
   } phase_cmd_t;
endpackage

// File: rtl/hcd_hall_map.sv
module hcd_hall_map
   import hcd_pkg::*;
(
   input  logic                   [2:0] hall_i,
   input  logic                         rev_i,
   output phase_cmd_t [NPH-1:0]         cmd_o,
   output logic                         valid_o
);
   logic [2:0] eff;
   logic [2:0] key;

   // reverse direction: complement every sensor bit
   assign eff     = rev_i ? ~hall_i : hall_i;
   // key ordered sensor1, sensor2, sensor3 (msb first)
   assign key     = {eff[0], eff[1], eff[2]};
   assign valid_o = (key != 3'b000) && (key != 3'b111);

   always_comb begin
      cmd_o = '{default: PH_OFF};
      unique case (key)
         3'b010: begin cmd_o[0] = PH_HIGH; cmd_o[1] = PH_LOW;  cmd_o[2] = PH_OFF;  end
         3'b011: begin cmd_o[0] = PH_HIGH; cmd_o[1] = PH_OFF;  cmd_o[2] = PH_LOW;  end
         3'b001: begin cmd_o[0] = PH_OFF;  cmd_o[1] = PH_HIGH; cmd_o[2] = PH_LOW;  end
         3'b101: begin cmd_o[0] = PH_LOW;  cmd_o[1] = PH_HIGH; cmd_o[2] = PH_OFF;  end
         3'b100: begin cmd_o[0] = PH_LOW;  cmd_o[1] = PH_OFF;  cmd_o[2] = PH_HIGH; end
         3'b110: begin cmd_o[0] = PH_OFF;  cmd_o[1] = PH_LOW;  cmd_o[2] = PH_HIGH; end
         default: cmd_o = '{default: PH_OFF};
      endcase
   end
endmodule

// File: rtl/hcd_uv_monitor.sv
module hcd_uv_monitor #(
   parameter int VW      = 8,
   parameter int UV_FALL = 100,
   parameter int UV_RISE = 112
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [VW-1:0] vsup_i,
   output logic          lock_o
);
   localparam logic [VW-1:0] FALL_C = VW'(UV_FALL);
   localparam logic [VW-1:0] RISE_C = VW'(UV_RISE);

   initial begin
      assert (UV_RISE > UV_FALL) else $error("hcd_uv_monitor: UV_RISE must exceed UV_FALL");
      assert (UV_RISE < (1 << VW)) else $error("hcd_uv_monitor: UV_RISE does not fit VW");
   end

   logic lock_q;
   logic below_fall;
   logic below_rise;

   assign below_fall = vsup_i < FALL_C;
   assign below_rise = vsup_i < RISE_C;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lock_q <= 1'b1;
      else if (lock_q) lock_q <= below_rise;
      else             lock_q <= below_fall;
   end

   assign lock_o = lock_q;

   // R6: a reading below the falling threshold always locks
   a_r6_trip_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (vsup_i < FALL_C) |=> lock_o);
   // R6: while locked, only a reading at or above the rising threshold releases
   a_r6_hold_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_o && (vsup_i < RISE_C)) |=> lock_o);
endmodule

// File: rtl/hcd_ilim_blank.sv
module hcd_ilim_blank (
   input  logic clk,
   input  logic rst_n,
   input  logic pwm_on_i,
   input  logic ilim_i,
   output logic blank_o
);
   logic pwm_prev_q;
   logic blank_q;
   logic period_start;

   assign period_start = pwm_on_i & ~pwm_prev_q;
   // trip blanks at once; the latch drops only at a period start
   assign blank_o      = ilim_i | (blank_q & ~period_start);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwm_prev_q <= 1'b0;
         blank_q    <= 1'b0;
      end else begin
         pwm_prev_q <= pwm_on_i;
         blank_q    <= blank_o;
      end
   end

   // R8: without a new period the blanking persists
   a_r8_blank_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_q && !pwm_on_i) |=> blank_q);
endmodule

// File: rtl/hcd_phase_gate.sv
module hcd_phase_gate #(
   parameter int DEAD_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic up_req_i,
   input  logic lo_req_i,
   output logic up_o,
   output logic lo_o
);
   localparam int CW = $clog2(DEAD_CYC + 1) + 1;
   localparam logic [CW-1:0] DEAD_C = CW'(DEAD_CYC);

   initial begin
      assert (DEAD_CYC >= 1) else $error("hcd_phase_gate: DEAD_CYC must be at least 1");
   end

   logic          up_q, lo_q;
   logic [CW-1:0] quiet_q;
   logic          idle;
   logic          may_on;

   assign idle   = ~up_q & ~lo_q;
   assign may_on = idle & (quiet_q == DEAD_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_q    <= 1'b0;
         lo_q    <= 1'b0;
         quiet_q <= '0;
      end else begin
         up_q <= up_req_i & (up_q | may_on);
         lo_q <= lo_req_i & (lo_q | may_on) & ~up_req_i;
         if (!idle)                quiet_q <= '0;
         else if (quiet_q != DEAD_C) quiet_q <= quiet_q + 1'b1;
      end
   end

   assign up_o = up_q;
   assign lo_o = lo_q;

   // R9: no shoot-through
   a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(up_o && lo_o));
   // R10: a rising upper enable follows at least two idle cycles of its phase
   a_r10_up_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(up_o) |-> ($past(!lo_o) && $past(!lo_o, 2) && $past(!up_o, 2)));
   // R10: same for the lower enable
   a_r10_lo_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lo_o) |-> ($past(!up_o) && $past(!up_o, 2) && $past(!lo_o, 2)));
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
   import hcd_pkg::*;
#(
   parameter int DEAD_CYC  = 4,
   parameter int VW        = 8,
   parameter int UV_FALL   = 100,
   parameter int UV_RISE   = 112,
   parameter bit SYNC_RECT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    hall_i,
   input  logic          rev_i,
   input  logic          pwm_on_i,
   input  logic          stop_i,
   input  logic          init_rst_i,
   input  logic [VW-1:0] vsup_i,
   input  logic          ovt_i,
   input  logic          ilim_i,
   output logic [2:0]    up_en_o,
   output logic [2:0]    lo_en_o
);
   phase_cmd_t [NPH-1:0] cmd;
   logic                 key_valid;
   logic                 uv_lock;
   logic                 ilim_blank;
   logic                 kill_all;
   logic                 high_up;
   logic                 high_lo;
   logic [NPH-1:0]       up_req, lo_req;

   hcd_hall_map u_map (
      .hall_i  (hall_i),
      .rev_i   (rev_i),
      .cmd_o   (cmd),
      .valid_o (key_valid)
   );

   hcd_uv_monitor #(
      .VW      (VW),
      .UV_FALL (UV_FALL),
      .UV_RISE (UV_RISE)
   ) u_uv (
      .clk    (clk),
      .rst_n  (rst_n),
      .vsup_i (vsup_i),
      .lock_o (uv_lock)
   );

   hcd_ilim_blank u_ilim (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwm_on_i (pwm_on_i),
      .ilim_i   (ilim_i),
      .blank_o  (ilim_blank)
   );

   assign kill_all = stop_i | init_rst_i | uv_lock | ~key_valid;
   assign high_up  = pwm_on_i & ~ovt_i & ~ilim_blank;

   generate
      if (SYNC_RECT) begin : g_sync_rect
         assign high_lo = ~pwm_on_i;
      end else begin : g_freewheel
         assign high_lo = 1'b0;
      end
   endgenerate

   for (genvar p = 0; p < NPH; p++) begin : g_phase
      always_comb begin
         up_req[p] = 1'b0;
         lo_req[p] = 1'b0;
         if (!kill_all) begin
            unique case (cmd[p])
               PH_HIGH: begin up_req[p] = high_up; lo_req[p] = high_lo; end
               PH_LOW:  lo_req[p] = 1'b1;
               default: ;
            endcase
         end
      end

      hcd_phase_gate #(.DEAD_CYC(DEAD_CYC)) u_gate (
         .clk      (clk),
         .rst_n    (rst_n),
         .up_req_i (up_req[p]),
         .lo_req_i (lo_req[p]),
         .up_o     (up_en_o[p]),
         .lo_o     (lo_en_o[p])
      );
   end

   // R4: equal sensor levels drop every switch
   a_r4_invalid_off: assert property (@(posedge clk) disable iff (!rst_n)
      ((hall_i == 3'b000) || (hall_i == 3'b111)) |=> (up_en_o == 3'b000 && lo_en_o == 3'b000));
   // R5: stop or initial reset drop every switch
   a_r5_stop_off: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i || init_rst_i) |=> (up_en_o == 3'b000 && lo_en_o == 3'b000));
   // R7: overtemperature clears the upper switches
   a_r7_ovt_upper: assert property (@(posedge clk) disable iff (!rst_n)
      ovt_i |=> (up_en_o == 3'b000));
   // R8: a current-limit trip clears the upper switches
   a_r8_ilim_upper: assert property (@(posedge clk) disable iff (!rst_n)
      ilim_i |=> (up_en_o == 3'b000));
endmodule

// File: tb/hall_commutator_tb.sv
module hall_commutator_tb;
   localparam int DEAD = 2;
   localparam int VW   = 8;
   localparam int FALL = 100;
   localparam int RISE = 112;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    hall = 3'b101;
   logic          rev = 1'b0, pwm = 1'b1, stop = 1'b0, initr = 1'b0, ovt = 1'b0, ilim = 1'b0;
   logic [VW-1:0] vsup = 8'd90;
   logic [2:0]    up_en, lo_en;

   int checks = 0;
   int errors = 0;
   string tag = "R11";

   always #10 clk = ~clk;

   hall_commutator #(
      .DEAD_CYC(DEAD), .VW(VW), .UV_FALL(FALL), .UV_RISE(RISE), .SYNC_RECT(1'b1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .hall_i(hall), .rev_i(rev), .pwm_on_i(pwm),
      .stop_i(stop), .init_rst_i(initr), .vsup_i(vsup), .ovt_i(ovt), .ilim_i(ilim),
      .up_en_o(up_en), .lo_en_o(lo_en)
   );

   // reference model state
   bit m_up[3], m_lo[3];
   int m_quiet[3];
   bit m_uv, m_blk, m_pwm_prev;

   // phase states from the R1 table: 0 off, 1 high, 2 low; returns {ph3,ph2,ph1}
   function automatic logic [5:0] ref_row(input logic [2:0] key);
      case (key)
         3'b010: return {2'd0, 2'd2, 2'd1};
         3'b011: return {2'd2, 2'd0, 2'd1};
         3'b001: return {2'd2, 2'd1, 2'd0};
         3'b101: return {2'd0, 2'd1, 2'd2};
         3'b100: return {2'd1, 2'd0, 2'd2};
         3'b110: return {2'd1, 2'd2, 2'd0};
         default: return 6'd0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int p = 0; p < 3; p++) begin m_up[p] = 0; m_lo[p] = 0; m_quiet[p] = 0; end
         m_uv = 1; m_blk = 0; m_pwm_prev = 0;
      end else begin
         logic [2:0] c;
         logic [5:0] row;
         bit kill, blk, start;
         bit nu[3], nl[3];
         c = rev ? ~hall : hall;
         row = ref_row({c[0], c[1], c[2]});
         kill = stop || initr || m_uv || (c == 3'b000) || (c == 3'b111);
         start = pwm && !m_pwm_prev;
         blk = ilim || (m_blk && !start);
         for (int p = 0; p < 3; p++) begin
            bit ru, rl, idle;
            int st;
            st = row[2*p +: 2];
            ru = 0; rl = 0;
            if (!kill) begin
               if (st == 1) begin ru = pwm && !ovt && !blk; rl = !pwm; end
               else if (st == 2) rl = 1;
            end
            idle = !m_up[p] && !m_lo[p];
            nu[p] = ru && (m_up[p] || (idle && m_quiet[p] >= DEAD));
            nl[p] = rl && (m_lo[p] || (idle && m_quiet[p] >= DEAD));
            if (!idle) m_quiet[p] = 0;
            else if (m_quiet[p] < DEAD) m_quiet[p]++;
         end
         for (int p = 0; p < 3; p++) begin m_up[p] = nu[p]; m_lo[p] = nl[p]; end
         m_blk = blk;
         m_pwm_prev = pwm;
         m_uv = m_uv ? (vsup < RISE) : (vsup < FALL);
      end
   end

   // cycle-by-cycle comparison
   always @(negedge clk) begin
      if (rst_n) begin
         logic [2:0] eu, el;
         for (int p = 0; p < 3; p++) begin eu[p] = m_up[p]; el[p] = m_lo[p]; end
         checks++;
         if (up_en !== eu || lo_en !== el) begin
            errors++;
            $display("FAIL %s up=%b lo=%b expected up=%b lo=%b at %0t", tag, up_en, lo_en, eu, el, $time);
         end
         checks++;
         if ((up_en & lo_en) !== 3'b000) begin
            errors++;
            $display("FAIL R9 overlap up=%b lo=%b expected no common bit", up_en, lo_en);
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_eq(input string req, input logic [5:0] act, input logic [5:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s got %b expected %b", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired got running expected done");
      finish_run();
   end

   initial begin
      logic [2:0] seq [6] = '{3'b010, 3'b110, 3'b100, 3'b101, 3'b001, 3'b011};
      step(3);
      check_eq("R11", {up_en, lo_en}, 6'd0);   // in reset
      rst_n = 1'b1;
      step(1);
      check_eq("R11", {up_en, lo_en}, 6'd0);
      tag = "R6";
      step(5);
      check_eq("R6", {up_en, lo_en}, 6'd0);    // locked out of reset, below fall
      vsup = 8'd105; step(5);
      check_eq("R6", {up_en, lo_en}, 6'd0);    // band, still locked
      vsup = 8'd120; step(8);
      // key order in seq is IN1,IN2,IN3; hall bit0 is sensor1
      tag = "R1";
      foreach (seq[i]) begin hall = {seq[i][0], seq[i][1], seq[i][2]}; step(8); end
      hall = 3'b010; step(8);                  // key 010: ph1 high, ph2 low
      check_eq("R1", {up_en, lo_en}, {3'b001, 3'b010});
      tag = "R2";
      rev = 1'b1;
      foreach (seq[i]) begin hall = ~{seq[i][0], seq[i][1], seq[i][2]}; step(8); end
      hall = 3'b101; step(8);                  // complement of key 010
      check_eq("R2", {up_en, lo_en}, {3'b001, 3'b010});
      rev = 1'b0;
      tag = "R3";
      hall = 3'b101;                           // key 101: ph1 low, ph2 high
      for (int i = 0; i < 5; i++) begin pwm = 1'b1; step(6); pwm = 1'b0; step(5); end
      check_eq("R3", {up_en, lo_en}, {3'b000, 3'b011});
      pwm = 1'b1; step(6);
      check_eq("R3", {up_en, lo_en}, {3'b010, 3'b001});
      tag = "R4";
      hall = 3'b000; step(4);
      check_eq("R4", {up_en, lo_en}, 6'd0);
      hall = 3'b111; step(4);
      check_eq("R4", {up_en, lo_en}, 6'd0);
      tag = "R5";
      hall = 3'b101; step(8);
      stop = 1'b1; step(4);
      check_eq("R5", {up_en, lo_en}, 6'd0);
      stop = 1'b0; step(8);
      initr = 1'b1; step(4);
      check_eq("R5", {up_en, lo_en}, 6'd0);
      initr = 1'b0; step(8);
      tag = "R7";
      ovt = 1'b1; step(6);
      check_eq("R7", {up_en, lo_en}, {3'b000, 3'b001});
      pwm = 1'b0; step(6);
      check_eq("R7", {up_en, lo_en}, {3'b000, 3'b011});
      ovt = 1'b0; pwm = 1'b1; step(8);
      tag = "R8";
      ilim = 1'b1; step(1); ilim = 1'b0; step(6);
      check_eq("R8", {up_en, lo_en}, {3'b000, 3'b001}); // still blanked, no new period
      pwm = 1'b0; step(4); pwm = 1'b1; step(6);
      check_eq("R8", {up_en, lo_en}, {3'b010, 3'b001}); // re-armed at period start
      tag = "R6";
      vsup = 8'd105; step(4);
      check_eq("R6", {up_en, lo_en}, {3'b010, 3'b001}); // unlocked stays in band
      vsup = 8'd99; step(4);
      check_eq("R6", {up_en, lo_en}, 6'd0);
      vsup = 8'd105; step(4);
      check_eq("R6", {up_en, lo_en}, 6'd0);
      vsup = 8'd112; step(8);
      tag = "R10";
      for (int i = 0; i < 6; i++) begin rev = ~rev; step(7); end
      for (int i = 0; i < 6; i++) begin hall = {seq[i][0], seq[i][1], seq[i][2]}; rev = i[0]; step(3); end
      step(8);
      finish_run();
   end
endmodule